// File: doc/BRIEF.md
# Fixed-Latency Word Memory Model

This block stands in for a real SDRAM controller when a system is simulated or prototyped without one. It is a memory slave on a simple strobe, write-enable and acknowledge handshake. Every transfer is one 32-bit word. The block answers each access after a fixed number of clock cycles, and that number is set separately for reads and for writes. By default a read takes 14 cycles and a write takes 6. These defaults match the measured timing of a slow controller, so a system tuned against this model sees realistic stall patterns. The data lives in a small register array that is cleared at reset.

A master raises `stb` and holds `we`, `addr` and `wdata` stable until it sees `ack`. The acknowledge is a single-cycle pulse. On a read, `rdata` is valid during that pulse. A write lands in the array on the same edge that raises `ack`. If the master drops `stb` before the acknowledge arrives, the access is abandoned and nothing changes. A master that keeps `stb` high after the acknowledge starts its next access one cycle later. That cycle is the recovery cycle the real controller's masters expect.

Top module: `msim_slave`

## Requirements
- R1: After reset `ack` is 0, `rdata` is 0 and every stored word reads as 0.
- R2: For a read, number the first rising edge at which `stb` is sampled high as edge 1. `ack` rises at edge `RD_LAT` and falls at edge `RD_LAT`+1, so the access spans `RD_LAT` cycles (default 14).
- R3: A write follows the same rule with `WR_LAT` (default 6).
- R4: `ack` is high for exactly one cycle per completed access.
- R5: During the `ack` cycle of a read, `rdata` equals the word last written to the addressed location.
- R6: A write stores `wdata` on the edge that raises `ack`, and later reads of that location return it.
- R7: If `stb` is sampled low before the acknowledging edge, the access is abandoned. No `ack` follows, no write occurs, and the next `stb` starts a fresh count.
- R8: The edge that ends the `ack` cycle ignores `stb`. With `stb` held high, the next access counts from the edge after that, so consecutive acknowledges are latency+1 cycles apart.
- R9: The word index is (`addr` >> 2) modulo `DEPTH`. Bits 1:0 and the address bits above the index have no effect, so aliased addresses reach the same word.
- R10: The latency and direction of an access are fixed by `we` at edge 1. A later change of `we` within the same access changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb | input | 1 | Access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read, sampled at the first edge of an access |
| addr | input | AW (32) | Byte address, word aligned |
| wdata | input | DW (32) | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW (32) | Read data, valid while `ack` is high on a read |

## Verification
The assertions watch the handshake on every cycle. They check that `ack` never lasts two cycles and that it never appears without a strobe on the edge before it. A checker-side run counter confirms that each acknowledge arrives exactly read or write latency cycles into an unbroken strobe. Data behaviour needs the bench's scenarios: words surviving until read back, aborted writes leaving memory untouched, address aliasing, and direction fixed at the first edge. The bench checks these against a reference array under random and directed traffic.

// File: rtl/msim_pkg.sv
package msim_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

endpackage

// File: rtl/msim_lat_timer.sv
module msim_lat_timer
    import msim_pkg::*;
#(
    parameter int unsigned RD_LAT = 14,
    parameter int unsigned WR_LAT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic we,
    output logic fire,
    output logic fire_wr,
    output logic ack
);

    localparam int unsigned MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int unsigned CW      = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        op_e           op;
        logic          ack;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        op_e         cur_op;
        int unsigned lat;
        s_d     = s_q;
        fire    = 1'b0;
        cur_op  = s_q.busy ? s_q.op : (we ? OP_WR : OP_RD);
        lat     = (cur_op == OP_WR) ? WR_LAT : RD_LAT;
        fire_wr = (cur_op == OP_WR);
        if (s_q.ack) begin
            s_d.ack  = 1'b0;
            s_d.cnt  = '0;
            s_d.busy = 1'b0;
        end else if (!stb) begin
            s_d.cnt  = '0;
            s_d.busy = 1'b0;
        end else if (int'(s_q.cnt) == int'(lat) - 1) begin
            fire     = 1'b1;
            s_d.ack  = 1'b1;
            s_d.cnt  = '0;
            s_d.busy = 1'b0;
        end else begin
            s_d.cnt  = s_q.cnt + 1'b1;
            s_d.busy = 1'b1;
            s_d.op   = cur_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, busy: 1'b0, op: OP_RD, ack: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ack = s_q.ack;

endmodule

// File: rtl/msim_store.sv
module msim_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          fire_wr,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            rdata;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            if (fire_wr) begin
                s_d.mem[idx] = wdata;
            end else begin
                s_d.rdata = s_q.mem[idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;

endmodule

// File: rtl/msim_slave.sv
module msim_slave
    import msim_pkg::*;
#(
    parameter int unsigned RD_LAT = 14,
    parameter int unsigned WR_LAT = 6,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AW     = 32,
    parameter int unsigned DW     = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);

    localparam int unsigned IW = $clog2(DEPTH);

    initial begin
        if (RD_LAT < 1 || WR_LAT < 1) $error("latencies must be at least 1");
        if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) $error("DEPTH must be a power of two >= 2");
    end

    logic          fire;
    logic          fire_wr;
    logic [IW-1:0] word_idx;

    assign word_idx = IW'((addr >> 2) % AW'(DEPTH));

    msim_lat_timer #(
        .RD_LAT (RD_LAT),
        .WR_LAT (WR_LAT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .we      (we),
        .fire    (fire),
        .fire_wr (fire_wr),
        .ack     (ack)
    );

    msim_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .fire_wr (fire_wr),
        .idx     (word_idx),
        .wdata   (wdata),
        .rdata   (rdata)
    );

endmodule

// File: rtl/msim_checker.sv
module msim_checker #(
    parameter int unsigned RD_LAT = 14,
    parameter int unsigned WR_LAT = 6
) (
    input logic clk,
    input logic rst_n,
    input logic stb,
    input logic we,
    input logic ack
);

    int unsigned run_q;
    logic        op_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 0;
            op_wr_q <= 1'b0;
        end else if (ack || !stb) begin
            run_q <= 0;
        end else begin
            if (run_q == 0) op_wr_q <= we;
            run_q <= run_q + 1;
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);                                                   // R4

    AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(stb));                                      // R7

    AST_ABANDON_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !ack) |=> !ack);                                        // R7

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !op_wr_q) |-> (run_q == RD_LAT));                        // R2

    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && op_wr_q) |-> (run_q == WR_LAT));                         // R3

endmodule

bind msim_slave msim_checker #(
    .RD_LAT (RD_LAT),
    .WR_LAT (WR_LAT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .we    (we),
    .ack   (ack)
);

// File: tb/msim_slave_bench.sv
module msim_slave_bench;

    localparam int unsigned RD_LAT = 14;
    localparam int unsigned WR_LAT = 6;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned AW     = 32;
    localparam int unsigned DW     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ack;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msim_slave #(
        .RD_LAT (RD_LAT), .WR_LAT (WR_LAT), .DEPTH (DEPTH), .AW (AW), .DW (DW)
    ) u_msim_slave (
        .clk (clk), .rst_n (rst_n), .stb (stb), .we (we),
        .addr (addr), .wdata (wdata), .ack (ack), .rdata (rdata)
    );

    function automatic int widx(input logic [AW-1:0] a);
        return int'((a >> 2) % DEPTH);
    endfunction

    function automatic int exp_lat(input bit w, input bit chained);
        return (w ? int'(WR_LAT) : int'(RD_LAT)) + (chained ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Presents one access at a negedge and waits for ack. stb stays high afterwards.
    task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit chained, input string req, output logic [DW-1:0] got);
        int n = 0;
        we = w; addr = a; wdata = d; stb = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1 && chained) check(ack == 1'b0, "R4", ack, 0);
            if (ack) break;
            if (n > 200) break;
        end
        check(n == exp_lat(w, chained), req, n, exp_lat(w, chained));
        got = rdata;
        if (w) model[widx(a)] = d;
        else check(rdata == model[widx(a)], "R5", rdata, model[widx(a)]);
    endtask

    task automatic idle(input int cycles);
        stb = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] got;
        logic [AW-1:0] a;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ack == 1'b0, "R1", ack, 0);
        check(rdata == '0, "R1", rdata, 0);
        access(1'b0, 32'h0000_0024, '0, 1'b0, "R2", got);
        check(got == '0, "R1", got, 0);
        idle(1);

        // R3 / R6: write then read back
        access(1'b1, 32'h0000_0008, 32'hCAFE_0001, 1'b0, "R3", got);
        idle(1);
        access(1'b0, 32'h0000_0008, '0, 1'b0, "R2", got);
        check(got == 32'hCAFE_0001, "R6", got, 32'hCAFE_0001);
        idle(2);

        // R7: abandoned write, stb dropped one cycle short
        we = 1'b1; addr = 32'h0000_0008; wdata = 32'hDEAD_BEEF; stb = 1'b1;
        begin
            bit seen = 1'b0;
            repeat (WR_LAT - 1) begin
                @(negedge clk);
                if (ack) seen = 1'b1;
            end
            stb = 1'b0;
            repeat (3) begin
                @(negedge clk);
                if (ack) seen = 1'b1;
            end
            check(!seen, "R7", seen, 0);
        end
        // fresh count after abandon: full write latency again, on another word
        access(1'b1, 32'h0000_000C, 32'h1111_2222, 1'b0, "R7", got);
        idle(1);
        access(1'b0, 32'h0000_0008, '0, 1'b0, "R7", got);
        check(got == 32'hCAFE_0001, "R7", got, 32'hCAFE_0001);

        // R8: chained accesses with stb held high
        access(1'b1, 32'h0000_0010, 32'hA5A5_0010, 1'b1, "R8", got);
        access(1'b0, 32'h0000_0010, '0, 1'b1, "R8", got);
        access(1'b0, 32'h0000_000C, '0, 1'b1, "R8", got);
        idle(1);

        // R9: aliased address with low bits and upper bits set
        access(1'b1, 32'h0000_0014, 32'h0BAD_F00D, 1'b0, "R3", got);
        idle(1);
        a = 32'h0000_0014 + DEPTH * 4 * 3 + 32'h3;
        access(1'b0, a, '0, 1'b0, "R9", got);
        check(got == 32'h0BAD_F00D, "R9", got, 32'h0BAD_F00D);
        idle(1);

        // R10: we raised mid-read does not turn it into a write
        begin
            int n = 0;
            we = 1'b0; addr = 32'h0000_0014; wdata = 32'h7777_7777; stb = 1'b1;
            forever begin
                @(negedge clk);
                n++;
                if (n == 2) we = 1'b1;
                if (ack || n > 200) break;
            end
            check(n == RD_LAT, "R10", n, RD_LAT);
            check(rdata == 32'h0BAD_F00D, "R10", rdata, 32'h0BAD_F00D);
            idle(1);
            access(1'b0, 32'h0000_0014, '0, 1'b0, "R10", got);
        end
        idle(1);

        // random traffic
        for (int i = 0; i < 200; i++) begin
            bit w     = $urandom_range(0, 3) == 0;
            bit chain = (i > 0) && stb && ($urandom_range(0, 1) == 1);
            logic [AW-1:0] ra = $urandom;
            if (!chain) idle($urandom_range(1, 3));
            access(w, ra, $urandom, chain, w ? "R3" : "R2", got);
        end
        idle(2);
        check(ack == 1'b0, "R4", ack, 0);

        done = 1'b1;
        finish_run();
    end

endmodule